// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the execute stage of a small 8-bit core. Each clock cycle in which `valid_i` is high, it takes a 5-bit operation code, two register operands (`a_i` as destination/first operand, `b_i` as source) and an 8-bit immediate. It computes the result and updates an internal 8-bit status register. The result, a one-cycle write-back strobe and the status register are all registered, so they appear one rising edge after the operation is presented.

The operations fall into five classes. The add/subtract class covers add, add with carry, subtract, subtract with borrow, increment, decrement and two's complement. The compare class uses the subtract logic but writes nothing back. The bitwise class covers AND, OR, XOR, one's complement and clear-by-mask. The shift class covers logical shifts, the arithmetic right shift and rotates through carry. The last class sets or clears a single status bit. Each class changes only its own subset of flags and leaves every other status bit as it was. This is what lets a carry survive a loop counter update, and what lets a chain of compares report equality across several bytes.

Status bit positions: I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. Unless a requirement below says otherwise, N is result bit 7, Z is set when the result is 0x00, and S = N xor V.

Top module: `alu8_core`

## Requirements
- R1: While `rst_ni` is low, `res_o` is 0x00, `wb_o` is 0 and `sreg_o` is 0x00.
- R2: An operation presented with `valid_i` high shows its effect on `res_o`, `wb_o` and `sreg_o` after the next rising edge. In a cycle with `valid_i` low, `wb_o` is 0 after that edge and `sreg_o` and `res_o` keep their values.
- R3: Add (code 0) gives a+b. Add-with-carry (1) gives a+b+C. Subtract (2) gives a-b. Subtract-with-borrow (3) gives a-b-C. All four write back and update H, S, V, N, Z and C. H is the carry or borrow across bit 3, V is two's-complement overflow, and C is the carry out of bit 7 or the borrow into it.
- R4: Compare (4) works as code 2, compare-with-borrow (5) works as code 3, and compare-immediate (6) works as code 2 with `imm_i` as the subtrahend. All three update the same six flags, give `wb_o`=0, and leave `res_o` unchanged.
- R5: For codes 3 and 5, Z may stay 1 or become 0 but is never set by a zero result byte. It becomes 1 only if it was already 1 and the byte is zero.
- R6: Increment (7) and decrement (8) write a+1 and a-1 and update only S, V, N and Z, so C and H are kept. V is set when the result is 0x80 after an increment or 0x7F after a decrement.
- R7: AND (10), OR (11), XOR (12), one's complement (13, giving 0xFF-a) and clear-by-mask (14, giving a AND (0xFF-imm)) write back and update only S, V, N and Z, with V forced to 0.
- R8: Two's complement (9) writes 0x00-a, so 0x80 stays 0x80. It updates all six flags: H is the borrow from bit 3, V is set only when the result is 0x80, and C is set whenever the result is nonzero.
- R9: Logical left shift (15) moves a[7] into C and 0 into bit 0. Logical right shift (16) moves a[0] into C and 0 into bit 7. Arithmetic right shift (17) keeps bit 7 and moves a[0] into C. All write back, update S, V, N, Z and C with V = N xor C, and keep H.
- R10: Rotate left (18) puts the old C into bit 0 and a[7] into C. Rotate right (19) puts the old C into bit 7 and a[0] into C. Flags follow R9.
- R11: Bit set (20) and bit clear (21) force status bit `imm_i[2:0]` to 1 or 0, leave the other seven bits unchanged, give `wb_o`=0 and leave `res_o` unchanged.
- R12: Codes 22 to 31 give `wb_o`=0 and change neither `res_o` nor `sreg_o`.
- R13: Status bits I and T change only through codes 20 and 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination register value) |
| b_i | input | 8 | Second operand (source register value) |
| imm_i | input | 8 | Immediate: compare constant, clear mask, or status bit index in [2:0] |
| res_o | output | 8 | Registered result |
| wb_o | output | 1 | Result is to be written back (one cycle per operation) |
| sreg_o | output | 8 | Status register |

## Verification
Directed cases aim at operand pairs that separate neighbouring flag rules. These include 0x7F+1 and 0x80-1 for overflow against carry, nibble-boundary sums for H, 0x80 and 0x00 for two's complement, and increments with C preset to show that carry is kept. Two-byte compare chains are run with equal and unequal low bytes to tell a sticky Z apart from a plain zero test. Rotates are run with C both set and clear, to show the carry really enters the result. Bit set and clear on I and T, idle cycles and unused codes show what must stay untouched. A long run of pseudo-random operations, including unused codes, is then compared every cycle against the behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 5;
  localparam int SR_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_CPI  = 5'd6,  OP_INC  = 5'd7,
    OP_DEC  = 5'd8,  OP_NEG  = 5'd9,  OP_AND  = 5'd10, OP_OR   = 5'd11,
    OP_XOR  = 5'd12, OP_COM  = 5'd13, OP_CBR  = 5'd14, OP_LSL  = 5'd15,
    OP_LSR  = 5'd16, OP_ASR  = 5'd17, OP_ROL  = 5'd18, OP_ROR  = 5'd19,
    OP_BSET = 5'd20, OP_BCLR = 5'd21
  } alu_op_e;

  localparam int SR_C = 0;
  localparam int SR_Z = 1;
  localparam int SR_N = 2;
  localparam int SR_V = 3;
  localparam int SR_S = 4;
  localparam int SR_H = 5;
  localparam int SR_T = 6;
  localparam int SR_I = 7;

  localparam logic [SR_W-1:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [SR_W-1:0] MASK_SVNZ  = 8'b0001_1110;
  localparam logic [SR_W-1:0] MASK_SHIFT = 8'b0001_1111;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return op <= OP_BCLR;
  endfunction

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return op_known(op) && !(op inside {OP_CP, OP_CPC, OP_CPI, OP_BSET, OP_BCLR});
  endfunction

  function automatic logic [SR_W-1:0] op_flag_mask(input logic [OP_W-1:0] op);
    if (op inside {OP_INC, OP_DEC})      return MASK_SVNZ;
    else if (op <= OP_NEG)               return MASK_ARITH;
    else if (op <= OP_CBR)               return MASK_SVNZ;
    else if (op <= OP_ROR)               return MASK_SHIFT;
    else                                 return '0;
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] res_o,
  output logic [SR_W-1:0]   flags_o
);
  localparam int MSB = DATA_W - 1;
  localparam int HB  = DATA_W / 2 - 1;

  logic [DATA_W-1:0] x, y, r;
  logic              cin, is_sub, chain;
  logic [DATA_W:0]   ext;
  logic              h, v, n, z;

  always_comb begin
    x      = a_i;
    y      = b_i;
    cin    = 1'b0;
    is_sub = 1'b0;
    chain  = 1'b0;
    case (op_i)
      OP_ADC:  cin = c_i;
      OP_SUB,
      OP_CP:   is_sub = 1'b1;
      OP_SBC,
      OP_CPC:  begin is_sub = 1'b1; cin = c_i; chain = 1'b1; end
      OP_CPI:  begin is_sub = 1'b1; y = imm_i; end
      OP_INC:  y = DATA_W'(1);
      OP_DEC:  begin is_sub = 1'b1; y = DATA_W'(1); end
      OP_NEG:  begin is_sub = 1'b1; x = '0; y = a_i; end
      default: ;
    endcase
  end

  always_comb begin
    if (is_sub) ext = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
    else        ext = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    r = ext[MSB:0];
    if (is_sub) begin
      h = (~x[HB] & y[HB]) | (y[HB] & r[HB]) | (r[HB] & ~x[HB]);
      v = (x[MSB] & ~y[MSB] & ~r[MSB]) | (~x[MSB] & y[MSB] & r[MSB]);
    end else begin
      h = (x[HB] & y[HB]) | (y[HB] & ~r[HB]) | (~r[HB] & x[HB]);
      v = (x[MSB] & y[MSB] & ~r[MSB]) | (~x[MSB] & ~y[MSB] & r[MSB]);
    end
    n = r[MSB];
    // chained borrow ops may only clear Z
    z = (r == '0) && (!chain || z_i);
    flags_o         = '0;
    flags_o[SR_C]   = ext[DATA_W];
    flags_o[SR_Z]   = z;
    flags_o[SR_N]   = n;
    flags_o[SR_V]   = v;
    flags_o[SR_S]   = n ^ v;
    flags_o[SR_H]   = h;
    res_o           = r;
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic [SR_W-1:0]   flags_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] r;

  always_comb begin
    case (op_i)
      OP_AND:  r = a_i & b_i;
      OP_OR:   r = a_i | b_i;
      OP_XOR:  r = a_i ^ b_i;
      OP_COM:  r = ~a_i;
      OP_CBR:  r = a_i & ~imm_i;
      default: r = '0;
    endcase
    flags_o       = '0;
    flags_o[SR_Z] = (r == '0);
    flags_o[SR_N] = r[MSB];
    flags_o[SR_V] = 1'b0;
    flags_o[SR_S] = r[MSB];
    res_o         = r;
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic [SR_W-1:0]   flags_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] r;
  logic              c, n, v;

  always_comb begin
    case (op_i)
      OP_LSL:  {c, r} = {a_i, 1'b0};
      OP_LSR:  {r, c} = {1'b0, a_i};
      OP_ASR:  {r, c} = {a_i[MSB], a_i};
      OP_ROL:  {c, r} = {a_i, c_i};
      OP_ROR:  {r, c} = {c_i, a_i};
      default: {c, r} = '0;
    endcase
    n             = r[MSB];
    v             = n ^ c;
    flags_o       = '0;
    flags_o[SR_C] = c;
    flags_o[SR_Z] = (r == '0);
    flags_o[SR_N] = n;
    flags_o[SR_V] = v;
    flags_o[SR_S] = n ^ v;
    res_o         = r;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wb_o,
  output logic [SR_W-1:0]   sreg_o
);
  localparam int IDX_W = $clog2(SR_W);

  logic [DATA_W-1:0] ar_res, lg_res, sh_res, sel_res;
  logic [SR_W-1:0]   ar_flg, lg_flg, sh_flg, sel_flg;
  logic [SR_W-1:0]   mask, sreg_nxt, bit_sel;
  logic [DATA_W-1:0] res_q;
  logic [SR_W-1:0]   sreg_q;
  logic              wb_q, take;

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .c_i(sreg_q[SR_C]), .z_i(sreg_q[SR_Z]),
    .res_o(ar_res), .flags_o(ar_flg)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
    .res_o(lg_res), .flags_o(lg_flg)
  );

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i(op_i), .a_i(a_i), .c_i(sreg_q[SR_C]),
    .res_o(sh_res), .flags_o(sh_flg)
  );

  always_comb begin
    if (op_i <= OP_NEG)      begin sel_res = ar_res; sel_flg = ar_flg; end
    else if (op_i <= OP_CBR) begin sel_res = lg_res; sel_flg = lg_flg; end
    else                     begin sel_res = sh_res; sel_flg = sh_flg; end
    mask    = op_flag_mask(op_i);
    bit_sel = SR_W'(1) << imm_i[IDX_W-1:0];
    case (op_i)
      OP_BSET: sreg_nxt = sreg_q | bit_sel;
      OP_BCLR: sreg_nxt = sreg_q & ~bit_sel;
      default: sreg_nxt = (sreg_q & ~mask) | (sel_flg & mask);
    endcase
    take = valid_i && op_known(op_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      wb_q   <= 1'b0;
      sreg_q <= '0;
    end else begin
      wb_q <= take && op_writes(op_i);
      if (take) begin
        sreg_q <= sreg_nxt;
        if (op_writes(op_i)) res_q <= sel_res;
      end
    end
  end

  assign res_o  = res_q;
  assign wb_o   = wb_q;
  assign sreg_o = sreg_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wb_o && $stable(sreg_o) && $stable(res_o));

  assert_cmp_no_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_CP, OP_CPC, OP_CPI}) |=> !wb_o && $stable(res_o));

  assert_z_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_SBC, OP_CPC}) && !sreg_o[SR_Z] |=> !sreg_o[SR_Z]);

  assert_carry_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_INC, OP_DEC})
    |=> sreg_o[SR_C] == $past(sreg_o[SR_C]) && sreg_o[SR_H] == $past(sreg_o[SR_H]));

  assert_v_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_CBR}) |=> !sreg_o[SR_V]);

  assert_shift_sign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR})
    |=> sreg_o[SR_S] == (sreg_o[SR_N] ^ sreg_o[SR_V]) && sreg_o[SR_V] == (sreg_o[SR_N] ^ sreg_o[SR_C]));

  assert_single_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {OP_BSET, OP_BCLR}) |=> !wb_o && $countones(sreg_o ^ $past(sreg_o)) <= 1);

  assert_unused_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i > OP_BCLR |=> !wb_o && $stable(sreg_o) && $stable(res_o));

  assert_it_guard_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i inside {OP_BSET, OP_BCLR})) |=> $stable(sreg_o[SR_I:SR_T]));

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid;
  logic [4:0] op;
  logic [7:0] a, b, imm;
  logic [7:0] res;
  logic       wb;
  logic [7:0] sreg;

  int checks = 0;
  int errors = 0;
  int m_sreg = 0;
  int m_res = 0;
  int m_wb = 0;

  always #5 clk = ~clk;

  alu8_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .imm_i(imm),
    .res_o(res), .wb_o(wb), .sreg_o(sreg)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int bitof(input int v, input int i);
    return (v >> i) & 1;
  endfunction

  function automatic string req_of(input int o);
    if (o <= 3) return "R3";
    if (o <= 6) return "R4";
    if (o <= 8) return "R6";
    if (o == 9) return "R8";
    if (o <= 14) return "R7";
    if (o <= 17) return "R9";
    if (o <= 19) return "R10";
    if (o <= 21) return "R11";
    return "R12";
  endfunction

  // behavioural reference: flags as integers, then merged by bit
  task automatic model(input int o, input int ua, input int ub, input int ui);
    int cf, zf, x, y, ci, t, r, sv, msk, h, v, n, c, z;
    int nr;
    cf = bitof(m_sreg, 0);
    zf = bitof(m_sreg, 1);
    msk = 0; h = 0; v = 0; c = 0; r = 0;
    m_wb = 0;
    if (o == 0 || o == 1 || o == 7) begin
      y  = (o == 7) ? 1 : ub;
      ci = (o == 1) ? cf : 0;
      t  = ua + y + ci;
      r  = t & 255;
      c  = (t > 255) ? 1 : 0;
      h  = (((ua & 15) + (y & 15) + ci) > 15) ? 1 : 0;
      sv = sx(ua) + sx(y) + ci;
      v  = (sv > 127 || sv < -128) ? 1 : 0;
      msk = (o == 7) ? 'h1E : 'h3F;
    end else if ((o >= 2 && o <= 6) || o == 8 || o == 9) begin
      x  = (o == 9) ? 0 : ua;
      y  = (o == 9) ? ua : (o == 6) ? ui : (o == 8) ? 1 : ub;
      ci = (o == 3 || o == 5) ? cf : 0;
      t  = x - y - ci;
      r  = t & 255;
      c  = (t < 0) ? 1 : 0;
      h  = (((x & 15) - (y & 15) - ci) < 0) ? 1 : 0;
      sv = sx(x) - sx(y) - ci;
      v  = (sv > 127 || sv < -128) ? 1 : 0;
      msk = (o == 8) ? 'h1E : 'h3F;
    end else if (o >= 10 && o <= 14) begin
      case (o)
        10: r = ua & ub;
        11: r = ua | ub;
        12: r = ua ^ ub;
        13: r = 255 - ua;
        default: r = ua & (255 - ui);
      endcase
      v = 0;
      msk = 'h1E;
    end else if (o >= 15 && o <= 19) begin
      case (o)
        15: begin r = (ua * 2) & 255; c = ua / 128; end
        16: begin r = ua / 2; c = ua % 2; end
        17: begin r = ua / 2 + ((ua >= 128) ? 128 : 0); c = ua % 2; end
        18: begin r = (ua * 2 + cf) & 255; c = ua / 128; end
        default: begin r = ua / 2 + cf * 128; c = ua % 2; end
      endcase
      v = (r / 128) ^ c;
      msk = 'h1F;
    end
    n = r / 128;
    z = (r == 0) ? 1 : 0;
    if (o == 3 || o == 5) z = z & zf;
    nr = c | (z << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4) | (h << 5);
    if (o == 20) m_sreg = m_sreg | (1 << (ui % 8));
    else if (o == 21) m_sreg = m_sreg & ~(1 << (ui % 8)) & 255;
    else if (o <= 19) m_sreg = (m_sreg & ~msk & 255) | (nr & msk);
    if (o <= 19 && !(o >= 4 && o <= 6)) begin
      m_wb = 1;
      m_res = r;
    end
  endtask

  task automatic step(input int o, input int ua, input int ub, input int ui);
    int old_it;
    old_it = m_sreg / 64;
    valid = 1'b1; op = 5'(o); a = 8'(ua); b = 8'(ub); imm = 8'(ui);
    @(posedge clk);
    @(negedge clk);
    model(o, ua, ub, ui);
    check(req_of(o), "res", int'(res), m_res);
    check(req_of(o), "wb", int'(wb), m_wb);
    check(req_of(o), "sreg", int'(sreg), m_sreg);
    if (o == 3 || o == 5) check("R5", "Z", int'(sreg[1]), bitof(m_sreg, 1));
    if (o != 20 && o != 21) check("R13", "I/T", int'(sreg[7:6]), old_it);
    valid = 1'b0;
  endtask

  task automatic idle();
    valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle wb", int'(wb), 0);
    check("R2", "idle sreg", int'(sreg), m_sreg);
    check("R2", "idle res", int'(res), m_res);
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; op = '0; a = '0; b = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset res", int'(res), 0);
    check("R1", "reset wb", int'(wb), 0);
    check("R1", "reset sreg", int'(sreg), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 add/sub corners
    step(0, 'h7F, 'h01, 0);
    step(0, 'hFF, 'h01, 0);
    step(1, 'h10, 'h20, 0);
    step(0, 'h08, 'h08, 0);
    step(2, 'h00, 'h01, 0);
    step(3, 'h80, 'h01, 0);
    step(2, 'h80, 'h01, 0);
    // R4/R5 two-byte compare chains
    step(4, 'h34, 'h34, 0);
    step(5, 'h12, 'h12, 0);
    step(4, 'h35, 'h34, 0);
    step(5, 'h12, 'h12, 0);
    step(6, 'h1E, 0, 'h1E);
    step(6, 'h05, 0, 'h40);
    step(4, 'h01, 'h00, 0);
    step(3, 'h05, 'h05, 0);
    idle();
    // R6 carry preserved across inc/dec
    step(20, 0, 0, 0);
    step(7, 'h7F, 0, 0);
    step(7, 'hFF, 0, 0);
    step(8, 'h80, 0, 0);
    step(8, 'h01, 0, 0);
    step(21, 0, 0, 0);
    step(7, 'h0F, 0, 0);
    // R8 two's complement
    step(9, 'h80, 0, 0);
    step(9, 'h00, 0, 0);
    step(9, 'h01, 0, 0);
    step(9, 'h10, 0, 0);
    // R7 bitwise
    step(10, 'hF0, 'h3C, 0);
    step(11, 'h00, 'h00, 0);
    step(12, 'hAA, 'h55, 0);
    step(13, 'h00, 0, 0);
    step(14, 'hFF, 0, 'h03);
    // R9 / R10 shifts and rotates
    step(15, 'h81, 0, 0);
    step(16, 'h01, 0, 0);
    step(17, 'h81, 0, 0);
    step(18, 'h40, 0, 0);
    step(20, 0, 0, 0);
    step(18, 'h00, 0, 0);
    step(20, 0, 0, 0);
    step(19, 'h02, 0, 0);
    step(21, 0, 0, 0);
    step(19, 'h01, 0, 0);
    // R11 / R13 status bits
    step(20, 0, 0, 7);
    step(20, 0, 0, 6);
    step(0, 'h7F, 'h7F, 0);
    step(21, 0, 0, 7);
    step(20, 0, 0, 'hFD);
    // R12 unused codes
    step(22, 'h11, 'h22, 'h33);
    step(31, 'hFF, 'hFF, 'hFF);
    idle();
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 17 == 0) idle();
      else step(int'($urandom_range(0, 23)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule